// File: doc/BRIEF.md
# Measurement Mode and Rate Scheduler

This block decides when a measurement sequencer is told to run. It keeps a 2-bit operating-mode field and a 3-bit output-rate field. Host writes update these fields. The block then issues one-cycle start pulses to the sequencer and receives a done pulse when each measurement finishes.

In continuous mode, a tick-driven period timer paces the measurements. The first start comes two output periods after the mode or configuration write, and each later start follows one period after the previous one. Single mode runs one measurement. When it completes, the block writes the mode field back to an idle code with an internal completion flag set. Both idle codes issue no measurement. A power-enable output is high only while a measurement is in flight, so the front end is down between continuous measurements and in idle.

When a host write lands in the same cycle as internal activity, the host write wins. The block reports every mode change it makes itself as a one-cycle update word, so the register file that holds the mode register can follow it.

Top module: `meas_sched`

## Requirements
- R1: Reset state. While reset is low, the block holds the mode field at 01 (single) and the rate code at 100, and seq_start_o, mode_upd_o and pwr_en_o are low. The first start pulse appears in the first cycle after reset is released.
- R2: The mode codes 10 and 11 are both idle. While the mode field holds either code, seq_start_o stays low.
- R3: The rate code sets the period in timebase ticks, scaled by TICK_SCALE: 000→200, 001→100, 010→50, 011→20, 100→10, 101→5, 110→2. The reserved code 111 behaves as 100 (10 ticks).
- R4: In continuous mode (code 00), after a write to the mode field or the rate field, the first start occurs on the 2·P-th tick and the next start P ticks later. Cycles without a tick do not advance the schedule.
- R5: When a single measurement completes, the block does two things in the cycle after seq_done_i. It pulses mode_upd_o for one cycle with mode_upd_data_o = 8'h83, which is bit 7 set as the completion flag and mode bits [1:0] = 11. It also shows mode_o = 11.
- R6: pwr_en_o is high from the cycle in which seq_start_o is high until the clock edge that samples seq_done_i. Between continuous measurements pwr_en_o is low while mode_o stays 00.
- R7: Host writes take priority. No start pulse follows a cycle that carries a mode or rate write. A host mode write in the same cycle as a single-mode seq_done_i replaces the idle write-back, and then no mode_upd_o pulse is made.
- R8: A write of single mode while a measurement is in flight is deferred. When that measurement completes, no idle write-back occurs, and the single measurement starts in the next cycle.
- R9: At most one measurement is in flight. A continuous period boundary that arrives while a measurement is in flight is skipped, and the schedule keeps its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| mode_wr_i | input | 1 | Host write strobe for the mode field |
| mode_wdata_i | input | 2 | Mode value written by the host |
| cfg_wr_i | input | 1 | Host write strobe for the rate field |
| rate_wdata_i | input | 3 | Rate code written by the host |
| seq_done_i | input | 1 | Sequencer finished the measurement in flight |
| seq_start_o | output | 1 | One-cycle start pulse to the sequencer |
| mode_upd_o | output | 1 | Block-initiated mode register update strobe |
| mode_upd_data_o | output | 8 | Word written to the mode register on mode_upd_o |
| mode_o | output | 2 | Current mode field |
| pwr_en_o | output | 1 | Front-end power enable; low means powered down |

## Verification
Two pairs of events can fall in the same cycle. A host mode write can coincide with the done pulse of a single measurement, and a continuous period boundary can arrive while a measurement is still in flight. The bench drives the done pulse by hand so that it lands exactly on a host write. It then checks that the written mode survives with no update pulse. In the second case the bench holds the done pulse back across two period boundaries. It checks that no start is issued while power is on and that the next start lands on the original period grid. A sweep over all eight rate codes compares the first and second start positions against periods computed from the rate in hertz.

// File: rtl/meas_sched_pkg.sv
// Shared types and constants for the measurement scheduler.
// Assumes the timebase tick runs at 150 Hz times TICK_SCALE.
package meas_sched_pkg;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_SINGLE = 2'b01,
        MD_IDLE_A = 2'b10,
        MD_IDLE_B = 2'b11
    } mode_e;

    localparam logic [2:0] RATE_RESET       = 3'b100;
    localparam logic [7:0] SINGLE_DONE_WORD = 8'h83;
    localparam int unsigned SLOWEST_TICKS   = 200;

    // Ticks per output period at scale 1; the reserved code maps to the reset rate
    function automatic int unsigned base_ticks(input logic [2:0] code);
        case (code)
            3'b000:  return 200;
            3'b001:  return 100;
            3'b010:  return 50;
            3'b011:  return 20;
            3'b101:  return 5;
            3'b110:  return 2;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/meas_sched_rate_lut.sv
// Maps a rate code to its period and to the doubled first wait, both in ticks.
// Assumes TICK_SCALE keeps 2*200*TICK_SCALE inside CNT_W bits.
module meas_sched_rate_lut
    import meas_sched_pkg::*;
#(
    parameter int unsigned TICK_SCALE = 1,
    parameter int unsigned CNT_W      = 9
) (
    input  logic [2:0]       rate_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] first_o
);
    // Scale the base period and double it for the first wait
    always_comb begin
        period_o = CNT_W'(base_ticks(rate_i) * TICK_SCALE);
        first_o  = CNT_W'(2 * base_ticks(rate_i) * TICK_SCALE);
    end
endmodule

// File: rtl/meas_sched_timer.sv
// Tick-driven countdown for continuous mode. It reloads the doubled wait on any
// host write and flags each period boundary. Assumes period_i is at least 1.
module meas_sched_timer #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned RST_LOAD = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] first_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Boundary on the last tick of the countdown, unless a write restarts it
    assign expire_o = run_i && tick_i && !reload_i && (cnt_q == CNT_W'(1));

    // Count ticks down, restarting on a write and on each boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RST_LOAD);
        else if (reload_i)
            cnt_q <= first_i;
        else if (run_i && tick_i)
            cnt_q <= (cnt_q == CNT_W'(1)) ? period_i : cnt_q - CNT_W'(1);
    end

    // R4: the countdown never rests at zero, so no boundary can be lost
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);
endmodule

// File: rtl/meas_sched_fsm.sv
// Mode field, in-flight tracking and start issue. Host writes override internal
// updates. Assumes seq_done_i is pulsed only for a measurement that was started.
module meas_sched_fsm
    import meas_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_wdata_i,
    input  logic       cfg_wr_i,
    input  logic       expire_i,
    input  logic       seq_done_i,
    output logic [1:0] mode_o,
    output logic       start_o,
    output logic       busy_o,
    output logic       upd_o
);
    logic [1:0] mode_q, mode_n;
    logic       busy_q, pend_q, start_q, upd_q;
    logic       host_wr, single_fin, want;

    // Decode this cycle's events
    always_comb begin
        host_wr    = mode_wr_i || cfg_wr_i;
        single_fin = seq_done_i && busy_q && (mode_q == MD_SINGLE) && !pend_q;
        want       = !busy_q && !host_wr && ((mode_q == MD_SINGLE) || expire_i);
        if (mode_wr_i)       mode_n = mode_wdata_i;
        else if (single_fin) mode_n = MD_IDLE_B;
        else                 mode_n = mode_q;
    end

    // Register mode, in-flight state, deferred single request and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MD_SINGLE;
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            mode_q  <= mode_n;
            busy_q  <= want ? 1'b1 : (seq_done_i ? 1'b0 : busy_q);
            if (seq_done_i && busy_q) pend_q <= 1'b0;
            else if (mode_wr_i)       pend_q <= busy_q && (mode_wdata_i == MD_SINGLE);
            start_q <= want;
            upd_q   <= single_fin && !mode_wr_i;
        end
    end

    assign mode_o  = mode_q;
    assign start_o = start_q;
    assign busy_o  = busy_q;
    assign upd_o   = upd_q;

    // R7
    host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i || cfg_wr_i) |=> !start_q);
    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !seq_done_i) |=> !start_q);
    // R5
    rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> (mode_q == MD_IDLE_B));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |=> !start_q);
    // R6
    pwr_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);
endmodule

// File: rtl/meas_sched.sv
// Measurement mode and rate scheduler top. It holds the rate field, selects the
// rate for the timer and wires the mode controller. Assumes one-cycle strobes.
module meas_sched
    import meas_sched_pkg::*;
#(
    parameter int unsigned TICK_SCALE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_wdata_i,
    input  logic       cfg_wr_i,
    input  logic [2:0] rate_wdata_i,
    input  logic       seq_done_i,
    output logic       seq_start_o,
    output logic       mode_upd_o,
    output logic [7:0] mode_upd_data_o,
    output logic [1:0] mode_o,
    output logic       pwr_en_o
);
    localparam int unsigned CNT_W    = $clog2(2 * SLOWEST_TICKS * TICK_SCALE + 1);
    localparam int unsigned RST_LOAD = 2 * 10 * TICK_SCALE;

    logic [2:0]       rate_q, rate_sel;
    logic [CNT_W-1:0] period, first;
    logic             expire, busy, upd;

    // Hold the rate field
    always_ff @(posedge clk) begin
        if (!rst_n)        rate_q <= RATE_RESET;
        else if (cfg_wr_i) rate_q <= rate_wdata_i;
    end

    // A rate write takes effect in the same cycle it reloads the timer
    assign rate_sel = cfg_wr_i ? rate_wdata_i : rate_q;

    meas_sched_rate_lut #(.TICK_SCALE(TICK_SCALE), .CNT_W(CNT_W)) u_lut (
        .rate_i   (rate_sel),
        .period_o (period),
        .first_o  (first)
    );

    meas_sched_timer #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .run_i    (mode_o == MD_CONT),
        .reload_i (mode_wr_i || cfg_wr_i),
        .period_i (period),
        .first_i  (first),
        .expire_o (expire)
    );

    meas_sched_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (mode_wr_i),
        .mode_wdata_i (mode_wdata_i),
        .cfg_wr_i     (cfg_wr_i),
        .expire_i     (expire),
        .seq_done_i   (seq_done_i),
        .mode_o       (mode_o),
        .start_o      (seq_start_o),
        .busy_o       (busy),
        .upd_o        (upd)
    );

    assign pwr_en_o        = busy;
    assign mode_upd_o      = upd;
    assign mode_upd_data_o = upd ? SINGLE_DONE_WORD : 8'h00;
endmodule

// File: tb/meas_sched_bench.sv
// Sweeps every rate code and the mode transitions. Expected periods are derived
// from the output rate in hertz at a 150 Hz tick.
module meas_sched_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       mode_wr_i = 1'b0;
    logic [1:0] mode_wdata_i = 2'b00;
    logic       cfg_wr_i = 1'b0;
    logic [2:0] rate_wdata_i = 3'b000;
    logic       seq_done_i = 1'b0;
    logic       seq_start_o, mode_upd_o, pwr_en_o;
    logic [7:0] mode_upd_data_o;
    logic [1:0] mode_o;
    logic       resp_auto = 1'b1;
    int         total = 0;
    int         bad = 0;

    meas_sched u_meas_sched (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
        .cfg_wr_i(cfg_wr_i), .rate_wdata_i(rate_wdata_i),
        .seq_done_i(seq_done_i), .seq_start_o(seq_start_o),
        .mode_upd_o(mode_upd_o), .mode_upd_data_o(mode_upd_data_o),
        .mode_o(mode_o), .pwr_en_o(pwr_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Period in ticks: 150 Hz tick divided by the rate, rate given in centihertz
    function automatic int exp_ticks(input int code);
        int chz;
        case (code)
            0: chz = 75;   1: chz = 150;  2: chz = 300;  3: chz = 750;
            5: chz = 3000; 6: chz = 7500; default: chz = 1500;
        endcase
        return 15000 / chz;
    endfunction

    task automatic host_mode(input logic [1:0] v);
        mode_wr_i = 1'b1; mode_wdata_i = v;
        @(negedge clk);
        mode_wr_i = 1'b0;
    endtask

    task automatic measure(input int code);
        int p, n1, n2;
        p = exp_ticks(code); n1 = -1; n2 = -1;
        rate_wdata_i = 3'(code); cfg_wr_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        for (int n = 1; n <= 3*p + 1; n++) begin
            @(negedge clk);
            if (seq_start_o) begin
                if (n1 < 0) n1 = n; else if (n2 < 0) n2 = n;
            end
            if (n == 2*p) chk(pwr_en_o == 1'b1, "R6 power on in flight", int'(pwr_en_o), 1);
            if (n == 2*p + 1) chk(!pwr_en_o && mode_o == 2'b00, "R6 power off between",
                                  int'({pwr_en_o, mode_o}), 0);
        end
        chk(n1 == 2*p, "R3 R4 first start tick", n1, 2*p);
        chk(n2 == 3*p, "R3 R4 second start tick", n2, 3*p);
    endtask

    // Auto responder: done in the cycle after a start
    initial begin
        forever begin
            @(negedge clk);
            if (resp_auto) seq_done_i = seq_start_o;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(mode_o == 2'b01, "R1 reset mode", int'(mode_o), 1);
        chk(!seq_start_o && !mode_upd_o && !pwr_en_o, "R1 reset outputs low",
            int'({seq_start_o, mode_upd_o, pwr_en_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seq_start_o == 1'b1, "R1 first start after reset", int'(seq_start_o), 1);
        @(negedge clk);
        chk(mode_upd_o == 1'b1, "R5 update pulse", int'(mode_upd_o), 1);
        chk(mode_upd_data_o == 8'h83, "R5 update word", int'(mode_upd_data_o), 'h83);
        chk(mode_o == 2'b11, "R5 mode idle", int'(mode_o), 3);
        @(negedge clk);
        chk(!mode_upd_o, "R5 single pulse", int'(mode_upd_o), 0);

        // R3 R4 sweep of every rate code in continuous mode
        host_mode(2'b00);
        for (int c = 0; c < 8; c++) measure(c);

        // R4 no ticks, no progress
        tick_i = 1'b0; rate_wdata_i = 3'b110; cfg_wr_i = 1'b1;
        @(negedge clk); cfg_wr_i = 1'b0; cnt = 0;
        repeat (40) begin @(negedge clk); if (seq_start_o) cnt++; end
        chk(cnt == 0, "R4 no tick no start", cnt, 0);
        tick_i = 1'b1;

        // R2 both idle codes stay quiet
        for (int m = 2; m < 4; m++) begin
            host_mode(2'(m)); cnt = 0;
            repeat (40) begin @(negedge clk); if (seq_start_o) cnt++; end
            chk(cnt == 0, "R2 idle no start", cnt, 0);
            chk(!pwr_en_o, "R2 idle power off", int'(pwr_en_o), 0);
        end

        // R7 a rate write blocks the pending single start for one cycle
        host_mode(2'b01);
        rate_wdata_i = 3'b100; cfg_wr_i = 1'b1;
        @(negedge clk); cfg_wr_i = 1'b0;
        chk(!seq_start_o, "R7 start held by host write", int'(seq_start_o), 0);
        @(negedge clk);
        chk(seq_start_o, "R7 start after host write", int'(seq_start_o), 1);
        repeat (3) @(negedge clk);

        // R7 host mode write coincides with single done
        resp_auto = 1'b0;
        host_mode(2'b01);
        @(negedge clk);
        chk(seq_start_o, "R7 single started", int'(seq_start_o), 1);
        seq_done_i = 1'b1; mode_wr_i = 1'b1; mode_wdata_i = 2'b00;
        @(negedge clk);
        seq_done_i = 1'b0; mode_wr_i = 1'b0;
        chk(!mode_upd_o, "R7 no write-back on collision", int'(mode_upd_o), 0);
        chk(mode_o == 2'b00, "R7 host mode kept", int'(mode_o), 0);

        // R8 single request while a continuous measurement is in flight
        cnt = 0;
        while (!seq_start_o && cnt < 40) begin @(negedge clk); cnt++; end
        chk(seq_start_o, "R8 continuous start seen", int'(seq_start_o), 1);
        host_mode(2'b01);
        cnt = 0;
        repeat (3) begin @(negedge clk); if (seq_start_o) cnt++; end
        chk(cnt == 0, "R8 deferred while busy", cnt, 0);
        seq_done_i = 1'b1;
        @(negedge clk); seq_done_i = 1'b0;
        chk(!mode_upd_o && mode_o == 2'b01, "R8 no idle write-back",
            int'({mode_upd_o, mode_o}), 1);
        @(negedge clk);
        chk(seq_start_o, "R8 deferred single starts", int'(seq_start_o), 1);
        seq_done_i = 1'b1;
        @(negedge clk); seq_done_i = 1'b0;
        chk(mode_upd_o && mode_o == 2'b11, "R5 write-back after deferred single",
            int'({mode_upd_o, mode_o}), 7);

        // R9 boundaries while busy are skipped, phase kept (P = 2 ticks)
        rate_wdata_i = 3'b110; cfg_wr_i = 1'b1;
        @(negedge clk); cfg_wr_i = 1'b0;
        host_mode(2'b00);
        cnt = 0;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 4) chk(seq_start_o, "R9 first start", int'(seq_start_o), 1);
            if (n > 4 && n < 10 && seq_start_o) cnt++;
            if (n == 7) chk(pwr_en_o, "R6 power held in flight", int'(pwr_en_o), 1);
            if (n == 8) seq_done_i = 1'b1;
            if (n == 9) seq_done_i = 1'b0;
            if (n == 10) chk(seq_start_o, "R9 start on grid after skip", int'(seq_start_o), 1);
        end
        chk(cnt == 0, "R9 no start while busy", cnt, 0);
        seq_done_i = 1'b1;
        @(negedge clk); seq_done_i = 1'b0;
        resp_auto = 1'b1;
        host_mode(2'b10);
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule